// File: doc/BRIEF.md
# Encoder Output Line Timing Generator

This block paces one scan line on the output side of a television video encoder. It counts encoder output clocks from the start of a line and, from a set of programmed positions, drives three strobes that downstream analog stages use: the sync-tip interval, the gate for the colour burst and the window in which active picture is sent. It also exposes the current position within the line and a one-clock pulse on the last position of the line.

The six timing values are taken from ports. They are copied into internal holding registers only on the clock edge that closes a line. A value written partway through a line therefore changes nothing until the following line. Two of the values are scaled before use. The burst-close position has a fixed bias of 128 clocks added. The picture-window length is programmed in units of two clocks, so the window spans twice the programmed count. Every window includes its start position and excludes its end position.

Top module: `enc_line_timing`

## Requirements
- R1: `sync_o` is high exactly at positions p with 0 <= p < held sync width; a width of 0 gives no sync pulse.
- R2: `burst_o` is high exactly at positions p with burst_open <= p < burst_close + 128; the gate is never high when burst_open >= burst_close + 128.
- R3: `video_o` is high exactly at positions p with video_start <= p < video_start + 2 * video_half_len.
- R4: `pos_o` starts each line at 0, rises by one each clock and wraps to 0 after line_len - 1. A line_len of 0 or 1 gives one-clock lines in which `pos_o` stays at 0.
- R5: `eol_o` is high for one clock on the last position of each line (pos_o = line_len - 1, or every clock when line_len <= 1).
- R6: Timing inputs are captured on the clock edge that ends a line, while `eol_o` is high. Changes to the inputs at any other time have no effect on the current line, and take effect from position 0 of the next line.
- R7: While `rst_n` is low: `pos_o` = 0, `sync_o`, `burst_o` and `video_o` are low, and `eol_o` is high. The first clock edge after release captures the inputs, and the first line starts at position 0 in the following cycle.
- R8: All strobes and `eol_o` refer to the position shown on `pos_o` in the same cycle, with no added lag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Encoder output clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sync_width_i | input | CNT_W | End position of the sync tip |
| burst_open_i | input | CNT_W | Position where the burst gate opens |
| burst_close_i | input | CNT_W | Burst gate close position, less the 128-clock bias |
| video_start_i | input | CNT_W | First position of active picture |
| video_half_len_i | input | CNT_W | Active picture length in units of two clocks |
| line_len_i | input | CNT_W | Total clocks per line |
| sync_o | output | 1 | Sync-tip strobe |
| burst_o | output | 1 | Colour burst gate |
| video_o | output | 1 | Active picture window |
| pos_o | output | CNT_W | Position within the current line |
| eol_o | output | 1 | High on the last position of a line |

## Verification
The assertions assume that `line_len_i` is at most 2^CNT_W - 1, so the position counter never needs to run past its width. They also assume that the inputs may change at any time, because only the held copies matter. The assertion on the one-clock end-of-line pulse relies on the held line length being at least 2. The stimulus keeps every line length inside the counter range and uses lengths 0 and 1 only where the one-clock line itself is under test. It changes the inputs both at line ends and in the middle of lines, to exercise the capture rule.

// File: rtl/enc_line_pkg.sv
package enc_line_pkg;
  localparam int unsigned LINE_CW    = 11;
  localparam int unsigned BURST_BIAS = 128;

  // holding-register field slots (field k occupies bits [k*W +: W])
  localparam int unsigned FLD_SYNC_W  = 0;
  localparam int unsigned FLD_B_OPEN  = 1;
  localparam int unsigned FLD_B_CLOSE = 2;
  localparam int unsigned FLD_V_START = 3;
  localparam int unsigned FLD_V_HALF  = 4;
  localparam int unsigned FLD_LEN     = 5;
  localparam int unsigned FLD_COUNT   = 6;

  // strobe slots
  localparam int unsigned STB_SYNC  = 0;
  localparam int unsigned STB_BURST = 1;
  localparam int unsigned STB_VIDEO = 2;
  localparam int unsigned STB_COUNT = 3;
endpackage

// File: rtl/enc_line_shadow.sv
module enc_line_shadow #(
  parameter int unsigned N = 6,
  parameter int unsigned W = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [N*W-1:0] cfg_i,
  output logic [N*W-1:0] cfg_q,
  output logic [N*W-1:0] cfg_d
);
  logic [N*W-1:0] hold_r;

  always_comb begin
    cfg_d = load ? cfg_i : hold_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_r <= '0;
    end else if (load) begin
      hold_r <= cfg_i;
    end
  end

  assign cfg_q = hold_r;
endmodule

// File: rtl/enc_line_counter.sv
module enc_line_counter #(
  parameter int unsigned W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wrap,
  output logic [W-1:0] pos_q,
  output logic [W-1:0] pos_d
);
  logic [W-1:0] pos_r;

  always_comb begin
    pos_d = wrap ? '0 : pos_r + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_r <= '0;
    end else begin
      pos_r <= pos_d;
    end
  end

  assign pos_q = pos_r;
endmodule

// File: rtl/enc_line_span.sv
module enc_line_span #(
  parameter int unsigned XW = 13
) (
  input  logic [XW-1:0] pos,
  input  logic [XW-1:0] lo,
  input  logic [XW-1:0] hi,
  output logic          hit
);
  always_comb begin
    hit = (pos >= lo) && (pos < hi);
  end
endmodule

// File: rtl/enc_line_timing.sv
module enc_line_timing
  import enc_line_pkg::*;
#(
  parameter int unsigned CNT_W = LINE_CW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] sync_width_i,
  input  logic [CNT_W-1:0] burst_open_i,
  input  logic [CNT_W-1:0] burst_close_i,
  input  logic [CNT_W-1:0] video_start_i,
  input  logic [CNT_W-1:0] video_half_len_i,
  input  logic [CNT_W-1:0] line_len_i,
  output logic             sync_o,
  output logic             burst_o,
  output logic             video_o,
  output logic [CNT_W-1:0] pos_o,
  output logic             eol_o
);
  localparam int unsigned XW = CNT_W + 2;
  localparam int unsigned NF = FLD_COUNT;
  localparam int unsigned NS = STB_COUNT;

  logic [NF*CNT_W-1:0] cfg_in, cfg_q, cfg_d;
  logic [CNT_W-1:0]    pos_q, pos_d;
  logic                eol_q, eol_n;
  logic [NS-1:0]       stb_q, stb_n;
  logic [XW-1:0]       span_lo [NS];
  logic [XW-1:0]       span_hi [NS];
  logic [XW-1:0]       pos_x, len_x;

  assign cfg_in = {line_len_i, video_half_len_i, video_start_i,
                   burst_close_i, burst_open_i, sync_width_i};

  // holding registers: loaded on the edge that closes a line
  enc_line_shadow #(.N(NF), .W(CNT_W)) u_shadow (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (eol_q),
    .cfg_i (cfg_in),
    .cfg_q (cfg_q),
    .cfg_d (cfg_d)
  );

  enc_line_counter #(.W(CNT_W)) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .wrap  (eol_q),
    .pos_q (pos_q),
    .pos_d (pos_d)
  );

  // window bounds, evaluated against next-cycle position and settings
  always_comb begin
    pos_x = XW'(pos_d);
    len_x = XW'(cfg_d[FLD_LEN*CNT_W +: CNT_W]);
    span_lo[STB_SYNC]  = '0;
    span_hi[STB_SYNC]  = XW'(cfg_d[FLD_SYNC_W*CNT_W +: CNT_W]);
    span_lo[STB_BURST] = XW'(cfg_d[FLD_B_OPEN*CNT_W +: CNT_W]);
    span_hi[STB_BURST] = XW'(cfg_d[FLD_B_CLOSE*CNT_W +: CNT_W]) + XW'(BURST_BIAS);
    span_lo[STB_VIDEO] = XW'(cfg_d[FLD_V_START*CNT_W +: CNT_W]);
    span_hi[STB_VIDEO] = XW'(cfg_d[FLD_V_START*CNT_W +: CNT_W])
                       + (XW'(cfg_d[FLD_V_HALF*CNT_W +: CNT_W]) << 1);
    eol_n = (pos_x + XW'(1)) >= len_x;
  end

  for (genvar s = 0; s < NS; s++) begin : g_span
    enc_line_span #(.XW(XW)) u_span (
      .pos (pos_x),
      .lo  (span_lo[s]),
      .hi  (span_hi[s]),
      .hit (stb_n[s])
    );
  end

  // end-of-line resets high so the first edge after reset loads settings
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= '0;
      eol_q <= 1'b1;
    end else begin
      stb_q <= stb_n;
      eol_q <= eol_n;
    end
  end

  assign sync_o  = stb_q[STB_SYNC];
  assign burst_o = stb_q[STB_BURST];
  assign video_o = stb_q[STB_VIDEO];
  assign pos_o   = pos_q;
  assign eol_o   = eol_q;
endmodule

// File: rtl/enc_line_chk.sv
module enc_line_chk
  import enc_line_pkg::*;
#(
  parameter int unsigned N = 6,
  parameter int unsigned W = 11
) (
  input logic           clk,
  input logic           rst_n,
  input logic           eol,
  input logic [W-1:0]   pos,
  input logic           sync,
  input logic           burst,
  input logic           video,
  input logic [N*W-1:0] cfg_q
);
  logic [W-1:0] len_h, sync_h, bopen_h, vstart_h;

  assign len_h    = cfg_q[FLD_LEN*W +: W];
  assign sync_h   = cfg_q[FLD_SYNC_W*W +: W];
  assign bopen_h  = cfg_q[FLD_B_OPEN*W +: W];
  assign vstart_h = cfg_q[FLD_V_START*W +: W];

  // R4
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eol |=> (pos == '0));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eol |=> (pos == W'($past(pos) + 1'b1)));

  // R5
  eol_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eol && (len_h >= W'(2))) |=> (!eol || (len_h < W'(2))));

  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eol |=> $stable(cfg_q));

  // R1
  sync_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pos == '0) && (sync_h != '0)) |-> sync);

  // R2
  burst_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst) |-> (pos == bopen_h));

  // R3
  video_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(video) |-> (pos == vstart_h));
endmodule

bind enc_line_timing enc_line_chk #(.N(NF), .W(CNT_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .eol   (eol_o),
  .pos   (pos_o),
  .sync  (sync_o),
  .burst (burst_o),
  .video (video_o),
  .cfg_q (cfg_q)
);

// File: tb/test_enc_line_timing.sv
`timescale 1ns/1ps
module test_enc_line_timing;
  localparam int unsigned W     = 11;
  localparam int unsigned LIMIT = 20000;

  typedef struct packed {
    int sw; int bo; int bc; int vs; int vh; int len;
  } cfg_t;

  // stimulus table; expected strobes follow from R1..R5 per position
  localparam int NV = 7;
  localparam cfg_t VEC [NV] = '{
    '{4,   6,   0,   20,  8,   40},
    '{10,  150, 40,  200, 30,  300},
    '{0,   200, 10,  0,   5,   50},
    '{1,   0,   0,   0,   1,   1},
    '{0,   1,   0,   1,   3,   0},
    '{50,  0,   2047,15,  20,  20},
    '{64,  1000,900, 100, 500, 1100}
  };

  logic         clk, rst_n;
  logic [W-1:0] sync_width_i, burst_open_i, burst_close_i;
  logic [W-1:0] video_start_i, video_half_len_i, line_len_i;
  logic         sync_o, burst_o, video_o, eol_o;
  logic [W-1:0] pos_o;

  int tests, fails, cyc;

  enc_line_timing #(.CNT_W(W)) i_enc_line_timing (
    .clk              (clk),
    .rst_n            (rst_n),
    .sync_width_i     (sync_width_i),
    .burst_open_i     (burst_open_i),
    .burst_close_i    (burst_close_i),
    .video_start_i    (video_start_i),
    .video_half_len_i (video_half_len_i),
    .line_len_i       (line_len_i),
    .sync_o           (sync_o),
    .burst_o          (burst_o),
    .video_o          (video_o),
    .pos_o            (pos_o),
    .eol_o            (eol_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == LIMIT) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic drive(input cfg_t c);
    sync_width_i     = W'(c.sw);
    burst_open_i     = W'(c.bo);
    burst_close_i    = W'(c.bc);
    video_start_i    = W'(c.vs);
    video_half_len_i = W'(c.vh);
    line_len_i       = W'(c.len);
  endtask

  task automatic wait_eol();
    while (!eol_o) @(negedge clk);
  endtask

  task automatic chk_bit(input string tag, input int p, input logic got, input logic exp,
                         inout bit bad);
    if (got !== exp) begin
      $display("FAIL %s pos=%0d actual %b expected %b", tag, p, got, exp);
      bad = 1'b1;
    end
  endtask

  // walks one full line sampled at negedges; optional mid-line rewrite at pos 3
  task automatic check_line(input cfg_t c, input string tag, input bit mid, input cfg_t m);
    int n;
    n = (c.len <= 1) ? 1 : c.len;
    for (int k = 0; k < n; k++) begin
      bit bad;
      @(negedge clk);
      bad = 1'b0;
      tests = tests + 1;
      if (int'(pos_o) != k) begin
        $display("FAIL %s R4/R8 pos actual %0d expected %0d", tag, pos_o, k);
        bad = 1'b1;
      end
      chk_bit({tag, " R1 sync"},  k, sync_o,  logic'(k < c.sw), bad);
      chk_bit({tag, " R2 burst"}, k, burst_o, logic'(k >= c.bo && k < c.bc + 128), bad);
      chk_bit({tag, " R3 video"}, k, video_o, logic'(k >= c.vs && k < c.vs + 2 * c.vh), bad);
      chk_bit({tag, " R5 eol"},   k, eol_o,   logic'(k == n - 1), bad);
      if (bad) fails = fails + 1;
      if (mid && k == 3) drive(m);
    end
  endtask

  task automatic check_reset(input string tag);
    bit bad;
    bad = 1'b0;
    tests = tests + 1;
    if (pos_o !== '0) begin
      $display("FAIL %s R7 pos actual %0d expected 0", tag, pos_o);
      bad = 1'b1;
    end
    chk_bit({tag, " R7 sync"},  0, sync_o,  1'b0, bad);
    chk_bit({tag, " R7 burst"}, 0, burst_o, 1'b0, bad);
    chk_bit({tag, " R7 video"}, 0, video_o, 1'b0, bad);
    chk_bit({tag, " R7 eol"},   0, eol_o,   1'b1, bad);
    if (bad) fails = fails + 1;
  endtask

  initial begin
    tests = 0;
    fails = 0;
    cyc   = 0;
    rst_n = 1'b0;
    drive(VEC[0]);
    repeat (3) @(negedge clk);
    check_reset("boot");
    rst_n = 1'b1;

    // table walk: each entry applied before a line end, checked over one line
    for (int v = 0; v < NV; v++) begin
      drive(VEC[v]);
      wait_eol();
      check_line(VEC[v], "table", 1'b0, VEC[v]);
    end

    // R6: rewrite mid-line; current line keeps old values, next takes new
    drive(VEC[1]);
    wait_eol();
    check_line(VEC[1], "R6 hold", 1'b1, VEC[0]);
    wait_eol();
    check_line(VEC[0], "R6 next", 1'b0, VEC[0]);

    // R6: rewrite inside a short line, then a longer line follows
    check_line(VEC[0], "R6 short", 1'b1, VEC[2]);
    check_line(VEC[2], "R6 after", 1'b0, VEC[2]);

    // R7: reset in mid-line, then restart on fresh settings
    drive(VEC[1]);
    wait_eol();
    repeat (12) @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    check_reset("midline");
    drive(VEC[0]);
    @(negedge clk);
    check_reset("held");
    rst_n = 1'b1;
    check_line(VEC[0], "R7 restart", 1'b0, VEC[0]);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule